// File: doc/BRIEF.md
# Two-Block Micro-op Reorder and Compaction Network

This block sits behind a four-bank decoded micro-op cache. All banks of one set are read in the same cycle, and each bank returns four micro-op slots. Up to two extended blocks may be fetched in that cycle, and each block can occupy any subset of the banks. For each block the lookup logic supplies three things: a bank mask, the bank where the block's logical sequence begins, and an entry count. The entry count says how many micro-ops, counted back from the block's end, are to be delivered.

Within a block, micro-ops are stored newest-first. Slot 0 of the block's first logical bank holds the final micro-op. The network works in two combinational stages. The first stage puts each block's occupied banks into logical order. The second stage reverses the stored sequence into program order, drops everything older than the entry point and any slot the block does not use, and packs the first block's micro-ops followed by the second's into one 16-slot group. That group is registered and presented together with a valid count.

If both blocks need the same bank, only the first block is delivered in this cycle. A flag then tells the fetch logic to retry the second block in the next cycle.

Top module: `xbn_reorder_align`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_vld_o`, `out_defer_o`, `out_cnt_o` and `out_uops_o` are all zero.
- R2: Outputs are registered. Inputs presented before a rising clock edge appear at the outputs after that edge, so the latency is one cycle.
- R3: A block's occupied banks are taken in logical order. The order starts at the start bank and walks upward through the bank numbers, wrapping from 3 to 0. Banks whose mask bit is 0 are skipped. Mask bit b selects bank b.
- R4: A block is stored reversed. Logical slot index L = 4*j + k means slot k of the j-th occupied bank in logical order. L = 0 is the block's last micro-op. Output position i of a block delivering n micro-ops carries logical index n-1-i.
- R5: Only the n micro-ops nearest the block end are delivered, where n is the entry count. An entry count of 0 delivers nothing for that block.
- R6: An entry count larger than 4 times the number of mask bits set is clamped to that capacity.
- R7: When both blocks are delivered, the second block's micro-ops start at the output position right after the first block's last one. `out_cnt_o` is the sum of the two lengths.
- R8: When both blocks are valid and their masks share at least one bank, only the first block is delivered and `out_defer_o` is 1. Otherwise `out_defer_o` is 0.
- R9: When only the second block is valid, it is delivered starting at output position 0.
- R10: Output slots at positions at or above `out_cnt_o` are zero.
- R11: In a cycle after one in which neither block was valid, `out_vld_o` is 0 and `out_cnt_o` is 0. Otherwise `out_vld_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bank_data_i | input | 256 | Bank b slot k at bits [(4*b+k)*16 +: 16] |
| blk0_vld_i | input | 1 | First block requested |
| blk0_mask_i | input | 4 | Banks holding the first block |
| blk0_start_i | input | 2 | First logical bank of the first block |
| blk0_cnt_i | input | 5 | Entry count of the first block, back from its end |
| blk1_vld_i | input | 1 | Second block requested |
| blk1_mask_i | input | 4 | Banks holding the second block |
| blk1_start_i | input | 2 | First logical bank of the second block |
| blk1_cnt_i | input | 5 | Entry count of the second block |
| out_vld_o | output | 1 | A delivery group is present |
| out_defer_o | output | 1 | Second block deferred by a bank conflict |
| out_cnt_o | output | 5 | Number of valid micro-ops in the group |
| out_uops_o | output | 256 | Packed group; position i at bits [i*16 +: 16] |

## Verification
The hardest case to reach is one where a wrapped bank order, reversed storage, a partial entry count and a second block all affect the same output group. A wrong offset in any one of them only moves a few slots. The directed stimulus therefore gives every bank slot a distinct code that includes its bank and slot numbers. It then applies blocks whose start bank lies above a skipped bank, and pairs them with a second block that owns the remaining banks, so the seam between the two blocks sits at an odd position. A separate case uses overlapping masks with every other field kept legal, so the conflict rule alone decides the outcome.

// File: rtl/xbn_pkg.sv
package xbn_pkg;
    // Shortest of a requested length and the space that is available.
    function automatic int clamp_len(input int req, input int cap);
        return (req < cap) ? req : cap;
    endfunction
endpackage

// File: rtl/xbn_bank_order.sv
// Stage one: gathers the banks a block occupies into logical order.
module xbn_bank_order #(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_SLOTS = 4,
    parameter int UOP_W      = 16,
    localparam int BANK_W    = BANK_SLOTS * UOP_W,
    localparam int BW        = $clog2(NUM_BANKS),
    localparam int CW        = $clog2(NUM_BANKS * BANK_SLOTS + 1)
) (
    input  logic [NUM_BANKS*BANK_W-1:0] bank_data_i,
    input  logic [NUM_BANKS-1:0]        mask_i,
    input  logic [BW-1:0]               start_i,
    output logic [NUM_BANKS*BANK_W-1:0] seq_o,
    output logic [CW-1:0]               cap_o
);
    always_comb begin
        int k;
        int phys;
        seq_o = '0;
        k     = 0;
        for (int p = 0; p < NUM_BANKS; p++) begin
            phys = (int'(start_i) + p) % NUM_BANKS;
            if (mask_i[phys]) begin
                seq_o[k*BANK_W +: BANK_W] = bank_data_i[phys*BANK_W +: BANK_W];
                k = k + 1;
            end
        end
        cap_o = CW'(k * BANK_SLOTS);
    end
endmodule

// File: rtl/xbn_align.sv
// Stage two: turns reversed sequences into program order, trims them, packs them.
module xbn_align #(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_SLOTS = 4,
    parameter int UOP_W      = 16,
    localparam int TOT       = NUM_BANKS * BANK_SLOTS,
    localparam int CW        = $clog2(TOT + 1)
) (
    input  logic [TOT*UOP_W-1:0] seq0_i,
    input  logic [CW-1:0]        cnt0_i,
    input  logic [CW-1:0]        cap0_i,
    input  logic                 use0_i,
    input  logic [TOT*UOP_W-1:0] seq1_i,
    input  logic [CW-1:0]        cnt1_i,
    input  logic [CW-1:0]        cap1_i,
    input  logic                 use1_i,
    output logic [TOT*UOP_W-1:0] uops_o,
    output logic [CW-1:0]        total_o
);
    import xbn_pkg::*;

    always_comb begin
        int l0;
        int l1;
        int src;
        l0     = use0_i ? clamp_len(int'(cnt0_i), int'(cap0_i)) : 0;
        l1     = use1_i ? clamp_len(int'(cnt1_i), int'(cap1_i)) : 0;
        src    = 0;
        uops_o = '0;
        for (int i = 0; i < TOT; i++) begin
            if (i < l0) begin
                src = l0 - 1 - i;
                uops_o[i*UOP_W +: UOP_W] = seq0_i[src*UOP_W +: UOP_W];
            end else if (i < l0 + l1) begin
                src = l1 - 1 - (i - l0);
                uops_o[i*UOP_W +: UOP_W] = seq1_i[src*UOP_W +: UOP_W];
            end
        end
        total_o = CW'(l0 + l1);
    end
endmodule

// File: rtl/xbn_reorder_align.sv
module xbn_reorder_align #(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_SLOTS = 4,
    parameter int UOP_W      = 16,
    localparam int TOT       = NUM_BANKS * BANK_SLOTS,
    localparam int BW        = $clog2(NUM_BANKS),
    localparam int CW        = $clog2(TOT + 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [TOT*UOP_W-1:0]   bank_data_i,
    input  logic                   blk0_vld_i,
    input  logic [NUM_BANKS-1:0]   blk0_mask_i,
    input  logic [BW-1:0]          blk0_start_i,
    input  logic [CW-1:0]          blk0_cnt_i,
    input  logic                   blk1_vld_i,
    input  logic [NUM_BANKS-1:0]   blk1_mask_i,
    input  logic [BW-1:0]          blk1_start_i,
    input  logic [CW-1:0]          blk1_cnt_i,
    output logic                   out_vld_o,
    output logic                   out_defer_o,
    output logic [CW-1:0]          out_cnt_o,
    output logic [TOT*UOP_W-1:0]   out_uops_o
);
    typedef struct packed {
        logic                 vld;
        logic                 defer;
        logic [CW-1:0]        cnt;
        logic [TOT*UOP_W-1:0] uops;
    } state_t;

    state_t st_d, st_q;

    logic [TOT*UOP_W-1:0] seq_w [2];
    logic [CW-1:0]        cap_w [2];
    logic [NUM_BANKS-1:0] mask_w [2];
    logic [BW-1:0]        start_w [2];
    logic [TOT*UOP_W-1:0] packed_w;
    logic [CW-1:0]        total_w;
    logic                 conflict_w;
    logic                 use1_w;

    assign mask_w[0]  = blk0_mask_i;
    assign mask_w[1]  = blk1_mask_i;
    assign start_w[0] = blk0_start_i;
    assign start_w[1] = blk1_start_i;

    // Stage one, one copy per block fetched in the cycle.
    for (genvar g = 0; g < 2; g++) begin : g_order
        xbn_bank_order #(
            .NUM_BANKS (NUM_BANKS),
            .BANK_SLOTS(BANK_SLOTS),
            .UOP_W     (UOP_W)
        ) u_order (
            .bank_data_i(bank_data_i),
            .mask_i     (mask_w[g]),
            .start_i    (start_w[g]),
            .seq_o      (seq_w[g]),
            .cap_o      (cap_w[g])
        );
    end

    assign conflict_w = blk0_vld_i && blk1_vld_i && |(blk0_mask_i & blk1_mask_i);
    assign use1_w     = blk1_vld_i && !conflict_w;

    xbn_align #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_SLOTS(BANK_SLOTS),
        .UOP_W     (UOP_W)
    ) u_align (
        .seq0_i (seq_w[0]),
        .cnt0_i (blk0_cnt_i),
        .cap0_i (cap_w[0]),
        .use0_i (blk0_vld_i),
        .seq1_i (seq_w[1]),
        .cnt1_i (blk1_cnt_i),
        .cap1_i (cap_w[1]),
        .use1_i (use1_w),
        .uops_o (packed_w),
        .total_o(total_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = blk0_vld_i || blk1_vld_i;
        st_d.defer = conflict_w;
        st_d.cnt   = total_w;
        st_d.uops  = packed_w;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld_o   = st_q.vld;
    assign out_defer_o = st_q.defer;
    assign out_cnt_o   = st_q.cnt;
    assign out_uops_o  = st_q.uops;

    // A deferred second block means only the first block's banks were used.
    a_r8_defer_first_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_defer_o |-> (int'(out_cnt_o) <= BANK_SLOTS * $countones($past(blk0_mask_i))
                         && $past(blk0_vld_i) && $past(blk1_vld_i)));

    // The group never holds more than the two entry counts asked for.
    a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(blk0_vld_i && blk1_vld_i) |->
            (int'(out_cnt_o) <= int'($past(blk0_cnt_i)) + int'($past(blk1_cnt_i))));

    // An idle cycle leaves an empty, invalid group.
    a_r11_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(blk0_vld_i || blk1_vld_i) |-> (!out_vld_o && out_cnt_o == '0));

    // Positions past the valid count carry zero.
    for (genvar s = 0; s < TOT; s++) begin : g_tail
        a_r10_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (int'(out_cnt_o) <= s) |-> (out_uops_o[s*UOP_W +: UOP_W] == '0));
    end
endmodule

// File: tb/xbn_reorder_align_bench.sv
module xbn_reorder_align_bench;
    localparam int W   = 16;
    localparam int TOT = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TOT*W-1:0] bank_data = '0;
    logic            v0 = 1'b0, v1 = 1'b0;
    logic [3:0]      m0 = '0, m1 = '0;
    logic [1:0]      s0 = '0, s1 = '0;
    logic [4:0]      n0 = '0, n1 = '0;
    logic            out_vld, out_defer;
    logic [4:0]      out_cnt;
    logic [TOT*W-1:0] out_uops;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [TOT*W-1:0] exp_uops;
    int               exp_cnt;
    bit               exp_def;
    bit               exp_vld;

    always #10 clk = ~clk;

    xbn_reorder_align u_xbn_reorder_align (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bank_data_i (bank_data),
        .blk0_vld_i  (v0),
        .blk0_mask_i (m0),
        .blk0_start_i(s0),
        .blk0_cnt_i  (n0),
        .blk1_vld_i  (v1),
        .blk1_mask_i (m1),
        .blk1_start_i(s1),
        .blk1_cnt_i  (n1),
        .out_vld_o   (out_vld),
        .out_defer_o (out_defer),
        .out_cnt_o   (out_cnt),
        .out_uops_o  (out_uops)
    );

    function automatic logic [15:0] code(input logic [7:0] salt, input int b, input int k);
        return {salt, 4'(b), 4'(k)};
    endfunction

    // Micro-op at logical index idx of a block (idx 0 = block end).
    function automatic logic [15:0] blk_uop(input logic [7:0] salt, input logic [3:0] m,
                                            input logic [1:0] st, input int idx);
        int seen;
        seen = 0;
        for (int p = 0; p < 4; p++) begin
            int b;
            b = (int'(st) + p) % 4;
            if (m[b]) begin
                if (seen == idx / 4) return code(salt, b, idx % 4);
                seen++;
            end
        end
        return 16'h0;
    endfunction

    task automatic check(input string req, input string what, input logic [TOT*W-1:0] act,
                         input logic [TOT*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] salt,
                         input logic a0, input logic [3:0] am0, input logic [1:0] as0, input int an0,
                         input logic a1, input logic [3:0] am1, input logic [1:0] as1, input int an1);
        int l0, l1, cap0, cap1;
        bit conf;
        @(negedge clk);
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 4; k++)
                bank_data[(4*b+k)*W +: W] = code(salt, b, k);
        v0 = a0; m0 = am0; s0 = as0; n0 = 5'(an0);
        v1 = a1; m1 = am1; s1 = as1; n1 = 5'(an1);
        cap0 = 4 * $countones(am0);
        cap1 = 4 * $countones(am1);
        conf = a0 && a1 && ((am0 & am1) != 4'b0);
        l0 = a0 ? ((an0 < cap0) ? an0 : cap0) : 0;
        l1 = (a1 && !conf) ? ((an1 < cap1) ? an1 : cap1) : 0;
        exp_uops = '0;
        for (int i = 0; i < l0; i++) exp_uops[i*W +: W] = blk_uop(salt, am0, as0, l0 - 1 - i);
        for (int i = 0; i < l1; i++) exp_uops[(l0+i)*W +: W] = blk_uop(salt, am1, as1, l1 - 1 - i);
        exp_cnt = l0 + l1;
        exp_def = conf;
        exp_vld = a0 || a1;
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        check(req, "valid", {255'b0, out_vld}, {255'b0, exp_vld});
        check(req, "defer", {255'b0, out_defer}, {255'b0, exp_def});
        check(req, "count", {251'b0, out_cnt}, {251'b0, 5'(exp_cnt)});
        check(req, "uops (R10 tail zero)", out_uops, exp_uops);
    endtask

    task automatic t_reset();
        check("R1", "valid", {255'b0, out_vld}, '0);
        check("R1", "defer", {255'b0, out_defer}, '0);
        check("R1", "count", {251'b0, out_cnt}, '0);
        check("R1", "uops", out_uops, '0);
    endtask

    task automatic t_linear();
        apply(8'h11, 1'b1, 4'b0011, 2'd0, 8, 1'b0, 4'b0, 2'd0, 0);
        check_all("R2 R3 R4");
        // Reversed storage: position 0 is bank1 slot3, position 7 is bank0 slot0.
        check("R4", "first slot", {240'b0, out_uops[0 +: W]}, {240'b0, 16'h1113});
        check("R4", "last slot", {240'b0, out_uops[7*W +: W]}, {240'b0, 16'h1100});
    endtask

    task automatic t_wrap_partial();
        // Start at bank 3, skip bank 0, continue at bank 1; enter 5 back from end.
        apply(8'h22, 1'b1, 4'b1010, 2'd3, 5, 1'b0, 4'b0, 2'd0, 0);
        check_all("R3 R5");
        check("R3", "entry slot", {240'b0, out_uops[0 +: W]}, {240'b0, 16'h2210});
    endtask

    task automatic t_zero_and_clamp();
        apply(8'h33, 1'b1, 4'b0100, 2'd2, 0, 1'b0, 4'b0, 2'd0, 0);
        check_all("R5");
        apply(8'h34, 1'b1, 4'b0001, 2'd0, 20, 1'b0, 4'b0, 2'd0, 0);
        check_all("R6");
    endtask

    task automatic t_pair();
        apply(8'h44, 1'b1, 4'b0101, 2'd2, 7, 1'b1, 4'b1010, 2'd1, 8);
        check_all("R7");
        check("R7", "seam slot", {240'b0, out_uops[7*W +: W]}, {240'b0, 16'h4433});
    endtask

    task automatic t_conflict();
        apply(8'h55, 1'b1, 4'b0110, 2'd1, 6, 1'b1, 4'b1100, 2'd2, 5);
        check_all("R8");
    endtask

    task automatic t_second_only();
        apply(8'h66, 1'b0, 4'b1111, 2'd0, 3, 1'b1, 4'b1001, 2'd3, 6);
        check_all("R9");
    endtask

    task automatic t_idle();
        apply(8'h77, 1'b0, 4'b0011, 2'd0, 4, 1'b0, 4'b1100, 2'd2, 4);
        check_all("R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_wrap_partial();
        t_zero_and_clamp();
        t_pair();
        t_conflict();
        t_second_only();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule